// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control state of a small 32-bit processor: a status word that packs the current mode byte, a backup mode byte and a condition flag, plus a second-level backup status byte, two saved program counters, two scratch words, and two stack pointers. One control-register port selects a register by number. It has a combinational read path and a write path that updates on the clock edge. A second plain port reads and writes the live stack pointer, which is the copy that general register 15 uses.

The two stack pointers are banked against the live copy. Bit 7 of the current mode byte selects the stack mode. When that bit is 0, the interrupt stack pointer is the live copy and the user stack pointer is parked in its own slot. When the bit is 1, the roles are reversed. A status write that flips the stack-mode bit parks the live value in the outgoing slot and loads the live copy from the incoming slot, in the same clock edge. No data stream passes through the block, so every pin is a plain control or data pin with no valid/ready handshake.

Register numbers: 0 status, 1 condition, 2 interrupt stack pointer, 3 user stack pointer, 4 and 5 scratch, 6 saved PC, 7 second-level backup status, 8 second-level saved PC. Numbers 9 to 15 are unassigned.

Top module: `ctl_regfile_banked`

## Requirements
- R1: After reset, every register number reads zero and the live stack pointer reads zero.
- R2: A read of status (number 0) returns (backup byte AND 0xC1) in bits 15:8, (current byte AND 0xC0) in bits 7:0, with the condition flag ORed into bit 0. Bits 31:16 read zero.
- R3: A write to status loads the backup byte from write bits 15:8, the current byte from bits 7:0, and the condition flag from bit 0.
- R4: The condition register (number 1) reads the flag in bit 0 and zero elsewhere. A write to it changes only the flag, from write bit 0.
- R5: A status write that takes the stack-mode bit from 0 to 1 stores the old live stack pointer into the interrupt slot and loads the live stack pointer from the user slot.
- R6: A status write that takes the stack-mode bit from 1 to 0 stores the old live stack pointer into the user slot and loads the live stack pointer from the interrupt slot.
- R7: Number 2 reads and writes the live stack pointer when the stack-mode bit is 0, and its own slot when the bit is 1. Number 3 does the reverse.
- R8: The second-level backup status (number 7) is written from bits 7:0 and reads back that byte AND 0xC1.
- R9: Numbers 6 and 8 store all 32 written bits and read back with bit 0 forced to 0.
- R10: Numbers 4 and 5 are plain 32-bit storage. Numbers 9 to 15 read zero, and writes to them change nothing that the ports can see.
- R11: A read of a register in the same cycle as a write to it returns the old value. The new value and any stack swap appear after that clock edge.
- R12: The stack-pointer port writes the live copy at the clock edge. When a control write in the same cycle also targets the live copy (a stack-mode flip, or a number 2 or 3 write that is live), the control write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cr_num | input | 4 | Control register number |
| cr_we | input | 1 | Control register write enable |
| cr_wdata | input | 32 | Control register write data |
| cr_rdata | output | 32 | Control register read data, combinational |
| sp_we | input | 1 | Live stack pointer write enable |
| sp_wdata | input | 32 | Live stack pointer write data |
| sp_rdata | output | 32 | Live stack pointer value |

## Verification
Directed sequences toggle the stack-mode bit in both directions with distinct values in the live copy and in both slots. This shows whether the swap saves into the correct slot and reloads from the other one. Status writes that keep the mode bit unchanged show that no swap happens. Odd values written to the saved PCs, and all-ones written to the status bytes, expose the read masks. Writes to unassigned numbers, followed by reads of every register, show that nothing was touched. Seeded random sequences mix all register numbers with stack-port writes, and they exercise the collision rule and the old-value read rule against a bench model.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int XLEN  = 32;
  localparam int NUM_W = 4;

  localparam logic [NUM_W-1:0] RN_STATUS = 4'd0;
  localparam logic [NUM_W-1:0] RN_COND   = 4'd1;
  localparam logic [NUM_W-1:0] RN_ISTACK = 4'd2;
  localparam logic [NUM_W-1:0] RN_USTACK = 4'd3;
  localparam logic [NUM_W-1:0] RN_SCR0   = 4'd4;
  localparam logic [NUM_W-1:0] RN_SCR1   = 4'd5;
  localparam logic [NUM_W-1:0] RN_SPC    = 4'd6;
  localparam logic [NUM_W-1:0] RN_BB     = 4'd7;
  localparam logic [NUM_W-1:0] RN_BBPC   = 4'd8;

  localparam logic [7:0] BACKUP_MASK = 8'hC1;
  localparam logic [7:0] CUR_MASK    = 8'hC0;
  localparam int         SM_BIT      = 7;

  // plain storage slots
  localparam int NSLOT   = 4;
  localparam int SL_SPC  = 0;
  localparam int SL_BBPC = 1;
  localparam int SL_SCR0 = 2;
  localparam int SL_SCR1 = 3;
endpackage

// File: rtl/crf_status.sv
module crf_status
  import crf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_status,
  input  logic            wr_cond,
  input  logic            wr_bb,
  input  logic [XLEN-1:0] wdata,
  output logic [7:0]      cur_byte,
  output logic [7:0]      bak_byte,
  output logic [7:0]      bb_byte,
  output logic            cond
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_byte <= '0;
      bak_byte <= '0;
      bb_byte  <= '0;
      cond     <= 1'b0;
    end else begin
      if (wr_status) begin
        cur_byte <= wdata[7:0];
        bak_byte <= wdata[15:8];
      end
      if (wr_status || wr_cond) cond <= wdata[0];
      if (wr_bb) bb_byte <= wdata[7:0];
    end
  end

  p_status_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> (bak_byte == $past(wdata[15:8])) && (cur_byte == $past(wdata[7:0]))
                  && (cond == $past(wdata[0])));
  p_cond_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cond && !wr_status) |=> $stable(cur_byte) && $stable(bak_byte) && $stable(bb_byte));
endmodule

// File: rtl/crf_stack_bank.sv
module crf_stack_bank
  import crf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sm,
  input  logic            flip,
  input  logic            istk_wr,
  input  logic            ustk_wr,
  input  logic [XLEN-1:0] wdata,
  input  logic            sp_we,
  input  logic [XLEN-1:0] sp_wdata,
  output logic [XLEN-1:0] live_sp,
  output logic [XLEN-1:0] istk_view,
  output logic [XLEN-1:0] ustk_view
);
  logic [XLEN-1:0] islot, uslot;
  logic            live_by_cr;

  assign live_by_cr = flip || (istk_wr && !sm) || (ustk_wr && sm);
  assign istk_view  = sm ? islot : live_sp;
  assign ustk_view  = sm ? live_sp : uslot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_sp <= '0;
      islot   <= '0;
      uslot   <= '0;
    end else if (flip) begin
      if (!sm) begin
        islot   <= live_sp;
        live_sp <= uslot;
      end else begin
        uslot   <= live_sp;
        live_sp <= islot;
      end
    end else begin
      if (istk_wr) begin
        if (sm) islot <= wdata;
        else    live_sp <= wdata;
      end
      if (ustk_wr) begin
        if (sm) live_sp <= wdata;
        else    uslot <= wdata;
      end
      if (sp_we && !live_by_cr) live_sp <= sp_wdata;
    end
  end

  p_swap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !sm) |=> (live_sp == $past(uslot)) && (islot == $past(live_sp)));
  p_swap_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && sm) |=> (live_sp == $past(islot)) && (uslot == $past(live_sp)));
  p_port_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && istk_wr && !sm && sp_we) |=> live_sp == $past(wdata));
endmodule

// File: rtl/crf_plain_store.sv
module crf_plain_store
  import crf_pkg::*;
#(
  parameter int N = NSLOT
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] q [N]
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(q[i]));
  end
endmodule

// File: rtl/ctl_regfile_banked.sv
module ctl_regfile_banked
  import crf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] cr_num,
  input  logic             cr_we,
  input  logic [XLEN-1:0]  cr_wdata,
  output logic [XLEN-1:0]  cr_rdata,
  input  logic             sp_we,
  input  logic [XLEN-1:0]  sp_wdata,
  output logic [XLEN-1:0]  sp_rdata
);
  logic [7:0]      cur_byte, bak_byte, bb_byte;
  logic            cond, sm, flip;
  logic            wr_status, wr_cond, wr_bb, istk_wr, ustk_wr;
  logic [NSLOT-1:0] slot_we;
  logic [XLEN-1:0] slot_q [NSLOT];
  logic [XLEN-1:0] istk_view, ustk_view;

  assign wr_status = cr_we && (cr_num == RN_STATUS);
  assign wr_cond   = cr_we && (cr_num == RN_COND);
  assign wr_bb     = cr_we && (cr_num == RN_BB);
  assign istk_wr   = cr_we && (cr_num == RN_ISTACK);
  assign ustk_wr   = cr_we && (cr_num == RN_USTACK);
  assign sm        = cur_byte[SM_BIT];
  assign flip      = wr_status && (cr_wdata[SM_BIT] != sm);

  always_comb begin
    slot_we          = '0;
    slot_we[SL_SPC]  = cr_we && (cr_num == RN_SPC);
    slot_we[SL_BBPC] = cr_we && (cr_num == RN_BBPC);
    slot_we[SL_SCR0] = cr_we && (cr_num == RN_SCR0);
    slot_we[SL_SCR1] = cr_we && (cr_num == RN_SCR1);
  end

  crf_status u_status (
    .clk, .rst_n, .wr_status, .wr_cond, .wr_bb, .wdata(cr_wdata),
    .cur_byte, .bak_byte, .bb_byte, .cond
  );

  crf_stack_bank u_stack (
    .clk, .rst_n, .sm, .flip, .istk_wr, .ustk_wr, .wdata(cr_wdata),
    .sp_we, .sp_wdata, .live_sp(sp_rdata), .istk_view, .ustk_view
  );

  crf_plain_store #(.N(NSLOT)) u_store (
    .clk, .rst_n, .we(slot_we), .wdata(cr_wdata), .q(slot_q)
  );

  always_comb begin
    cr_rdata = '0;
    unique case (cr_num)
      RN_STATUS: cr_rdata[15:0] = {bak_byte & BACKUP_MASK, (cur_byte & CUR_MASK) | {7'd0, cond}};
      RN_COND:   cr_rdata[0]    = cond;
      RN_ISTACK: cr_rdata       = istk_view;
      RN_USTACK: cr_rdata       = ustk_view;
      RN_SCR0:   cr_rdata       = slot_q[SL_SCR0];
      RN_SCR1:   cr_rdata       = slot_q[SL_SCR1];
      RN_SPC:    cr_rdata       = {slot_q[SL_SPC][XLEN-1:1], 1'b0};
      RN_BB:     cr_rdata[7:0]  = bb_byte & BACKUP_MASK;
      RN_BBPC:   cr_rdata       = {slot_q[SL_BBPC][XLEN-1:1], 1'b0};
      default:   cr_rdata       = '0;
    endcase
  end

  p_keep_on_unassigned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && cr_num > RN_BBPC && !sp_we) |=> $stable(sp_rdata) && $stable(cond));
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_status) |=> $stable(sm));
endmodule

// File: tb/ctl_regfile_banked_test.sv
module ctl_regfile_banked_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cr_num = '0;
  logic        cr_we = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata;
  logic        sp_we = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic [31:0] sp_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_cur, m_bak, m_bb;
  logic        m_cond;
  logic [31:0] m_live, m_isl, m_usl, m_spc, m_bbpc, m_s0, m_s1;

  always #2.5 clk = ~clk;

  ctl_regfile_banked uut (
    .clk, .rst_n, .cr_num, .cr_we, .cr_wdata, .cr_rdata, .sp_we, .sp_wdata, .sp_rdata
  );

  function automatic string tag_of(input logic [3:0] n);
    case (n)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd2, 4'd3: return "R7";
      4'd4, 4'd5: return "R10";
      4'd6, 4'd8: return "R9";
      4'd7: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] n);
    logic sm;
    sm = m_cur[7];
    case (n)
      4'd0: return {16'd0, m_bak & 8'hC1, (m_cur & 8'hC0) | {7'd0, m_cond}};
      4'd1: return {31'd0, m_cond};
      4'd2: return sm ? m_isl : m_live;
      4'd3: return sm ? m_live : m_usl;
      4'd4: return m_s0;
      4'd5: return m_s1;
      4'd6: return {m_spc[31:1], 1'b0};
      4'd7: return {24'd0, m_bb & 8'hC1};
      4'd8: return {m_bbpc[31:1], 1'b0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_cur = 0; m_bak = 0; m_bb = 0; m_cond = 0;
    m_live = 0; m_isl = 0; m_usl = 0; m_spc = 0; m_bbpc = 0; m_s0 = 0; m_s1 = 0;
  endtask

  task automatic model_step(input logic [3:0] n, input logic we, input logic [31:0] wd,
                            input logic swe, input logic [31:0] swd);
    logic touch;
    logic [31:0] t;
    touch = 0;
    if (we) begin
      case (n)
        4'd0: begin
          if (wd[7] != m_cur[7]) begin
            touch = 1;
            t = m_live;
            if (wd[7]) begin m_live = m_usl; m_isl = t; end   // R5
            else       begin m_live = m_isl; m_usl = t; end   // R6
          end
          m_cur = wd[7:0]; m_bak = wd[15:8]; m_cond = wd[0];
        end
        4'd1: m_cond = wd[0];
        4'd2: if (!m_cur[7]) begin m_live = wd; touch = 1; end else m_isl = wd;
        4'd3: if (m_cur[7]) begin m_live = wd; touch = 1; end else m_usl = wd;
        4'd4: m_s0 = wd;
        4'd5: m_s1 = wd;
        4'd6: m_spc = wd;
        4'd7: m_bb = wd[7:0];
        4'd8: m_bbpc = wd;
        default: ;
      endcase
    end
    if (swe && !touch) m_live = swd;   // R12
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check reads (old values, R11), clock, update model
  task automatic op(input logic [3:0] n, input logic we, input logic [31:0] wd,
                    input logic swe = 0, input logic [31:0] swd = 0);
    @(negedge clk);
    cr_num = n; cr_we = we; cr_wdata = wd; sp_we = swe; sp_wdata = swd;
    #1;
    check(we ? "R11" : tag_of(n), cr_rdata, exp_read(n));
    check("R12", sp_rdata, m_live);
    @(posedge clk);
    model_step(n, we, wd, swe, swd);
    #0.5;
    cr_we = 0; sp_we = 0;
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      cr_num = 4'(k); cr_we = 0; sp_we = 0;
      #1;
      check(tag, cr_rdata, exp_read(4'(k)));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    read_all("R1");
    @(negedge clk); check("R1", sp_rdata, 32'd0);

    // status packing and write fields
    op(4'd0, 1, 32'h0000_FF3F);           // R3: mode bit stays 0
    read_all("R2");
    op(4'd1, 1, 32'h0000_0000);           // R4: flag only
    op(4'd0, 0, 0);
    op(4'd1, 1, 32'hFFFF_FFFF);
    op(4'd1, 0, 0);

    // banked pointers, mode 0
    op(4'd2, 1, 32'h1111_0000);           // R7 live
    op(4'd3, 1, 32'h2222_0000);           // R7 slot
    op(4'd0, 1, 32'h0000_0080);           // R5 flip 0->1
    read_all("R5");
    op(4'd2, 1, 32'h3333_0000);           // R7 slot now
    op(4'd0, 1, 32'h0000_0081);           // no flip
    op(4'd0, 1, 32'h0000_0000);           // R6 flip 1->0
    read_all("R6");

    // masks and storage
    op(4'd6, 1, 32'hDEAD_BEEF);
    op(4'd8, 1, 32'h0000_0001);
    op(4'd7, 1, 32'hFFFF_FFFF);
    op(4'd4, 1, 32'hA5A5_5A5A);
    op(4'd5, 1, 32'h0F0F_F0F0);
    read_all("R9");
    for (int k = 9; k < 16; k++) op(4'(k), 1, 32'hFFFF_FFFF);
    read_all("R10");

    // collisions
    op(4'd2, 1, 32'h4444_4444, 1, 32'h5555_5555);   // R12 cr wins
    op(4'd3, 1, 32'h6666_6666, 1, 32'h7777_7777);   // slot write, sp port writes
    op(4'd0, 1, 32'h0000_0080, 1, 32'h8888_8888);   // flip wins
    op(4'd6, 1, 32'h1234_5679);
    op(4'd6, 1, 32'h0000_0000);                     // R11 old value read

    for (int i = 0; i < 600; i++) begin
      logic [3:0]  n;
      logic [31:0] wd;
      n  = 4'($urandom_range(0, 15));
      wd = $urandom();
      if (n == 4'd0 && $urandom_range(0, 1) == 0) wd[7] = m_cur[7];
      op(n, $urandom_range(0, 2) != 0, wd, $urandom_range(0, 2) == 0, $urandom());
    end
    read_all("R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule